// File: doc/BRIEF.md
# Display Control Command Decoder

This block receives 32-bit display-control words. The opcode sits in bits 31:24 and the argument in bits 23:0. The block keeps the 32-bit status word of the graphics unit up to date. It also holds the display origin in frame memory and the vertical scan window. From the mode bits in the status word it derives the horizontal and vertical resolution. Information queries load a readback register with drawing-state values that the rasteriser supplies on input ports, or with fixed constants.

Each command is sampled on a rising clock edge while `cmd_valid_i` is high. Its effect shows on the outputs after that edge. A vertical-blank pulse flips the field bit of the status word. A transfer-start strobe from the pixel-transfer engine raises the transfer-busy bit. A reset-class command drops that bit again and raises an abort pulse, which cancels pending packets and transfers elsewhere in the pipeline.

Top module: `dc_ctrl_regs`

## Requirements
- R1: While reset is asserted and after it is released:
  - `status_o` is 0x14802000 and `width_o`/`height_o` are 256/240.
  - `disp_x_o`, `disp_y_o` and `vstart_o` are 0, and `vend_o` is 240.
  - `readback_o` is 0 and `abort_o` is low.
- R2: Opcodes 0x00 and 0x01 clear status bit 27 and pulse `abort_o` high for the one cycle after the command.
  - `xfer_start_i` sets bit 27.
  - When both happen in the same cycle, the clear wins.
  - `abort_o` is low in every other cycle.
- R3: Opcode 0x03 copies argument bit 0 into status bit 23.
- R4: Opcode 0x04 copies argument bits 1:0 into status bits 30:29.
- R5: Opcode 0x05 loads `disp_x_o` from argument bits 9:0 and `disp_y_o` from argument bits 18:10.
- R6: Opcode 0x07 loads `vstart_o` from argument bits 9:0 and `vend_o` from argument bits 19:10.
- R7: Opcode 0x08 writes argument bits 5:0 to status bits 22:17 and argument bit 6 to status bit 16.
- R8: Resolution is decoded from the status word.
  - `width_o` comes from status bits 18:16: index 0..7 gives 256, 368, 320, 384, 512, 512, 640, 640.
  - `height_o` comes from status bits 20:19: index 0..3 gives 240, 480, 256, 480.
  - `pal_o` equals status bit 20 and `depth24_o` equals status bit 21.
- R9: Opcode 0x10 loads `readback_o` according to argument bits 7:0:
  - 2: `tex_win_i` zero-extended.
  - 3: `area_y0_i<<10 | area_x0_i`.
  - 4: `((area_y1_i-1) mod 1024)<<10 | ((area_x1_i-1) mod 1024)`.
  - 5 or 6: `off_y_i<<11 | off_x_i`.
  - 7: the value 2.
  - 8 or 15: the value 0xBFC03720.
- R10: Each cycle with `vblank_i` high inverts status bit 31. Status bit 31 holds otherwise.
- R11: Some inputs change no output: any other opcode, opcode 0x10 with an unlisted index, and any word presented while `cmd_valid_i` is low.
- R12: Every command takes effect on the outputs exactly one clock after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word valid this cycle |
| cmd_i | input | 32 | Opcode in 31:24, argument in 23:0 |
| vblank_i | input | 1 | Vertical-blank pulse |
| xfer_start_i | input | 1 | Pixel transfer started, sets busy bit |
| tex_win_i | input | 20 | Current texture window setting |
| area_x0_i | input | 10 | Drawing area left edge |
| area_y0_i | input | 10 | Drawing area top edge |
| area_x1_i | input | 11 | Drawing area right bound, exclusive |
| area_y1_i | input | 11 | Drawing area bottom bound, exclusive |
| off_x_i | input | 11 | Drawing offset X |
| off_y_i | input | 11 | Drawing offset Y |
| status_o | output | 32 | Status word |
| width_o | output | 10 | Decoded horizontal resolution |
| height_o | output | 9 | Decoded vertical resolution |
| pal_o | output | 1 | PAL timing selected |
| depth24_o | output | 1 | 24-bit colour selected |
| disp_x_o | output | 10 | Display start X in frame memory |
| disp_y_o | output | 9 | Display start Y in frame memory |
| vstart_o | output | 10 | First displayed scanline |
| vend_o | output | 10 | Last displayed scanline bound |
| readback_o | output | 32 | Query result |
| abort_o | output | 1 | One-cycle packet/transfer abort pulse |

## Verification
Every output is a register, or is decoded straight from one. A wrong internal state therefore appears at the ports in the cycle after the command or pulse that caused it.

A corrupted mode field shows two ways. `status_o` differs, and `width_o`, `height_o`, `pal_o` and `depth24_o` show a wrong resolution or mode at once. A lost or doubled field toggle leaves bit 31 inverted from then on, so every later comparison of that bit exposes it. A readback value taken from the wrong source, or changed by an unlisted index, stays wrong on `readback_o` until the next listed query.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_RESET,
    OP_ENABLE,
    OP_DMA,
    OP_START,
    OP_VRANGE,
    OP_MODE,
    OP_QUERY
  } dc_op_e;

  localparam logic [31:0] STATUS_RST = 32'h1480_2000;

  localparam int unsigned ST_FIELD   = 31;
  localparam int unsigned ST_DMA_LO  = 29;
  localparam int unsigned ST_BUSY    = 27;
  localparam int unsigned ST_DIS     = 23;
  localparam int unsigned ST_DEPTH   = 21;
  localparam int unsigned ST_PAL     = 20;
  localparam int unsigned ST_VSEL_LO = 19;
  localparam int unsigned ST_MODE_LO = 17;
  localparam int unsigned ST_HX      = 16;

  localparam logic [31:0] QUERY_ID_CONST = 32'hBFC0_3720;
  localparam logic [31:0] QUERY_VER      = 32'd2;
endpackage

// File: rtl/dc_cmd_decode.sv
module dc_cmd_decode #(
  parameter int unsigned OP_W = 8
) (
  input  logic            valid_i,
  input  logic [OP_W-1:0] opcode_i,
  output dc_pkg::dc_op_e  op_o
);
  import dc_pkg::*;

  always_comb begin
    op_o = OP_NONE;
    if (valid_i) begin
      case (opcode_i)
        OP_W'(8'h00), OP_W'(8'h01): op_o = OP_RESET;
        OP_W'(8'h03):               op_o = OP_ENABLE;
        OP_W'(8'h04):               op_o = OP_DMA;
        OP_W'(8'h05):               op_o = OP_START;
        OP_W'(8'h07):               op_o = OP_VRANGE;
        OP_W'(8'h08):               op_o = OP_MODE;
        OP_W'(8'h10):               op_o = OP_QUERY;
        default:                    op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dc_res_decode.sv
module dc_res_decode #(
  parameter int unsigned WID_W = 10,
  parameter int unsigned HGT_W = 9
) (
  input  logic [2:0]       hsel_i,
  input  logic [1:0]       vsel_i,
  output logic [WID_W-1:0] width_o,
  output logic [HGT_W-1:0] height_o
);
  always_comb begin
    case (hsel_i)
      3'd0:       width_o = WID_W'(256);
      3'd1:       width_o = WID_W'(368);
      3'd2:       width_o = WID_W'(320);
      3'd3:       width_o = WID_W'(384);
      3'd4, 3'd5: width_o = WID_W'(512);
      default:    width_o = WID_W'(640);
    endcase
  end

  always_comb begin
    case (vsel_i)
      2'd0:    height_o = HGT_W'(240);
      2'd2:    height_o = HGT_W'(256);
      default: height_o = HGT_W'(480);
    endcase
  end
endmodule

// File: rtl/dc_query.sv
module dc_query #(
  parameter int unsigned TEX_W = 20,
  parameter int unsigned AXY_W = 10,
  parameter int unsigned OFF_W = 11,
  parameter int unsigned RB_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [7:0]       idx_i,
  input  logic [TEX_W-1:0] tex_win_i,
  input  logic [AXY_W-1:0] area_x0_i,
  input  logic [AXY_W-1:0] area_y0_i,
  input  logic [AXY_W:0]   area_x1_i,
  input  logic [AXY_W:0]   area_y1_i,
  input  logic [OFF_W-1:0] off_x_i,
  input  logic [OFF_W-1:0] off_y_i,
  output logic [RB_W-1:0]  rb_o
);
  import dc_pkg::*;

  localparam int unsigned CORNER_W = 2 * AXY_W;
  localparam int unsigned OFFS_W   = 2 * OFF_W;

  logic [AXY_W:0]  x_last, y_last;
  logic [RB_W-1:0] rb_q;

  assign x_last = area_x1_i - 1'b1;
  assign y_last = area_y1_i - 1'b1;

  logic unused_top;
  assign unused_top = x_last[AXY_W] ^ y_last[AXY_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_q <= '0;
    end else if (load_i) begin
      case (idx_i)
        8'd2:        rb_q <= RB_W'(tex_win_i);
        8'd3:        rb_q <= RB_W'({area_y0_i, area_x0_i});
        8'd4:        rb_q <= RB_W'(CORNER_W'({y_last[AXY_W-1:0], x_last[AXY_W-1:0]}));
        8'd5, 8'd6:  rb_q <= RB_W'(OFFS_W'({off_y_i, off_x_i}));
        8'd7:        rb_q <= RB_W'(QUERY_VER);
        8'd8, 8'd15: rb_q <= RB_W'(QUERY_ID_CONST);
        default:     rb_q <= rb_q;
      endcase
    end
  end

  assign rb_o = rb_q;
endmodule

// File: rtl/dc_ctrl_regs.sv
module dc_ctrl_regs #(
  parameter int unsigned DX_W  = 10,
  parameter int unsigned DY_W  = 9,
  parameter int unsigned VR_W  = 10,
  parameter int unsigned TEX_W = 20,
  parameter int unsigned AXY_W = 10,
  parameter int unsigned OFF_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [31:0]      cmd_i,
  input  logic             vblank_i,
  input  logic             xfer_start_i,
  input  logic [TEX_W-1:0] tex_win_i,
  input  logic [AXY_W-1:0] area_x0_i,
  input  logic [AXY_W-1:0] area_y0_i,
  input  logic [AXY_W:0]   area_x1_i,
  input  logic [AXY_W:0]   area_y1_i,
  input  logic [OFF_W-1:0] off_x_i,
  input  logic [OFF_W-1:0] off_y_i,
  output logic [31:0]      status_o,
  output logic [9:0]       width_o,
  output logic [8:0]       height_o,
  output logic             pal_o,
  output logic             depth24_o,
  output logic [DX_W-1:0]  disp_x_o,
  output logic [DY_W-1:0]  disp_y_o,
  output logic [VR_W-1:0]  vstart_o,
  output logic [VR_W-1:0]  vend_o,
  output logic [31:0]      readback_o,
  output logic             abort_o
);
  import dc_pkg::*;

  localparam int unsigned OP_W  = 8;
  localparam int unsigned WID_W = 10;
  localparam int unsigned HGT_W = 9;
  localparam int unsigned ARG_W = 32 - OP_W;

  dc_op_e          op;
  logic [ARG_W-1:0] arg;
  logic [31:0]     status_q, status_d;
  logic [DX_W-1:0] disp_x_q;
  logic [DY_W-1:0] disp_y_q;
  logic [VR_W-1:0] vstart_q, vend_q;
  logic            abort_q;

  assign arg = cmd_i[ARG_W-1:0];

  logic unused_arg;
  assign unused_arg = ^arg[ARG_W-1:2*VR_W];

  dc_cmd_decode #(.OP_W(OP_W)) i_decode (
    .valid_i  (cmd_valid_i),
    .opcode_i (cmd_i[31:ARG_W]),
    .op_o     (op)
  );

  always_comb begin
    status_d = status_q;
    if (vblank_i)     status_d[ST_FIELD] = ~status_q[ST_FIELD];
    if (xfer_start_i) status_d[ST_BUSY]  = 1'b1;
    case (op)
      OP_RESET:  status_d[ST_BUSY] = 1'b0;
      OP_ENABLE: status_d[ST_DIS] = arg[0];
      OP_DMA:    status_d[ST_DMA_LO +: 2] = arg[1:0];
      OP_MODE: begin
        status_d[ST_MODE_LO +: 6] = arg[5:0];
        status_d[ST_HX]           = arg[6];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= STATUS_RST;
      abort_q  <= 1'b0;
    end else begin
      status_q <= status_d;
      abort_q  <= (op == OP_RESET);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_x_q <= '0;
      disp_y_q <= '0;
      vstart_q <= '0;
      vend_q   <= VR_W'(240);
    end else begin
      if (op == OP_START) begin
        disp_x_q <= arg[DX_W-1:0];
        disp_y_q <= arg[DX_W +: DY_W];
      end
      if (op == OP_VRANGE) begin
        vstart_q <= arg[VR_W-1:0];
        vend_q   <= arg[VR_W +: VR_W];
      end
    end
  end

  dc_res_decode #(.WID_W(WID_W), .HGT_W(HGT_W)) i_res (
    .hsel_i   (status_q[ST_HX +: 3]),
    .vsel_i   (status_q[ST_VSEL_LO +: 2]),
    .width_o  (width_o),
    .height_o (height_o)
  );

  dc_query #(
    .TEX_W(TEX_W), .AXY_W(AXY_W), .OFF_W(OFF_W), .RB_W(32)
  ) i_query (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (op == OP_QUERY),
    .idx_i     (arg[7:0]),
    .tex_win_i (tex_win_i),
    .area_x0_i (area_x0_i),
    .area_y0_i (area_y0_i),
    .area_x1_i (area_x1_i),
    .area_y1_i (area_y1_i),
    .off_x_i   (off_x_i),
    .off_y_i   (off_y_i),
    .rb_o      (readback_o)
  );

  assign status_o  = status_q;
  assign pal_o     = status_q[ST_PAL];
  assign depth24_o = status_q[ST_DEPTH];
  assign disp_x_o  = disp_x_q;
  assign disp_y_o  = disp_y_q;
  assign vstart_o  = vstart_q;
  assign vend_o    = vend_q;
  assign abort_o   = abort_q;
endmodule

// File: rtl/dc_ctrl_chk.sv
module dc_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic [31:0] cmd_i,
  input logic        vblank_i,
  input logic        xfer_start_i,
  input logic [31:0] status_o,
  input logic [9:0]  width_o,
  input logic [9:0]  disp_x_o,
  input logic [8:0]  disp_y_o,
  input logic [9:0]  vstart_o,
  input logic [9:0]  vend_o,
  input logic [31:0] readback_o,
  input logic        abort_o
);
  logic [7:0] opc;
  logic       is_rst_cmd, is_known, is_listed_q;
  assign opc         = cmd_i[31:24];
  assign is_rst_cmd  = cmd_valid_i && (opc == 8'h00 || opc == 8'h01);
  assign is_known    = opc inside {8'h00, 8'h01, 8'h03, 8'h04, 8'h05, 8'h07, 8'h08, 8'h10};
  assign is_listed_q = cmd_i[7:0] inside {8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8, 8'd15};

  p_abort_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rst_cmd |=> (!status_o[27] && abort_o));

  p_abort_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_rst_cmd |=> !abort_o);

  p_enable_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && opc == 8'h03) |=> (status_o[23] == $past(cmd_i[0])));

  p_start_pos_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && opc == 8'h05) |=>
      (disp_x_o == $past(cmd_i[9:0]) && disp_y_o == $past(cmd_i[18:10])));

  p_vrange_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && opc == 8'h07) |=>
      (vstart_o == $past(cmd_i[9:0]) && vend_o == $past(cmd_i[19:10])));

  p_mode_bits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && opc == 8'h08) |=>
      (status_o[22:16] == {$past(cmd_i[5:0]), $past(cmd_i[6])}));

  p_width_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_o == 10'd256 || width_o == 10'd368 || width_o == 10'd320 ||
     width_o == 10'd384 || width_o == 10'd512 || width_o == 10'd640));

  p_field_flip_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_i |=> (status_o[31] != $past(status_o[31])));

  p_field_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vblank_i |=> $stable(status_o[31]));

  p_unknown_inert_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!cmd_valid_i || !is_known) && !xfer_start_i) |=>
      ($stable(status_o[30:0]) && $stable(disp_x_o) && $stable(disp_y_o) &&
       $stable(vstart_o) && $stable(vend_o) && $stable(readback_o)));

  p_query_unlisted_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && opc == 8'h10 && !is_listed_q) |=> $stable(readback_o));
endmodule

bind dc_ctrl_regs dc_ctrl_chk i_dc_ctrl_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_i        (cmd_i),
  .vblank_i     (vblank_i),
  .xfer_start_i (xfer_start_i),
  .status_o     (status_o),
  .width_o      (width_o),
  .disp_x_o     (disp_x_o),
  .disp_y_o     (disp_y_o),
  .vstart_o     (vstart_o),
  .vend_o       (vend_o),
  .readback_o   (readback_o),
  .abort_o      (abort_o)
);

// File: tb/test_dc_ctrl_regs.sv
module test_dc_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] cmd = '0;
  logic        vblank = 1'b0;
  logic        xstart = 1'b0;
  logic [19:0] tex_win = '0;
  logic [9:0]  ax0 = '0, ay0 = '0;
  logic [10:0] ax1 = 11'd1, ay1 = 11'd1;
  logic [10:0] ox = '0, oy = '0;

  logic [31:0] status, readback;
  logic [9:0]  width, disp_x, vstart, vend;
  logic [8:0]  height, disp_y;
  logic        pal, depth24, abort_p;

  always #5 clk = ~clk;

  dc_ctrl_regs i_dc_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_i(cmd),
    .vblank_i(vblank), .xfer_start_i(xstart), .tex_win_i(tex_win),
    .area_x0_i(ax0), .area_y0_i(ay0), .area_x1_i(ax1), .area_y1_i(ay1),
    .off_x_i(ox), .off_y_i(oy), .status_o(status), .width_o(width),
    .height_o(height), .pal_o(pal), .depth24_o(depth24), .disp_x_o(disp_x),
    .disp_y_o(disp_y), .vstart_o(vstart), .vend_o(vend),
    .readback_o(readback), .abort_o(abort_p)
  );

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    cmp_en = 0;
  string cur_req = "R1";

  // reference model state
  bit       m_field, m_busy, m_dis, m_abort;
  bit [1:0] m_dma;
  bit [6:0] m_mode;
  int       m_x, m_y, m_vs, m_ve;
  bit [31:0] m_rb;

  function automatic bit [31:0] exp_status();
    bit [31:0] s;
    s = 32'h0000_2000;
    s[31] = m_field;
    s[30:29] = m_dma;
    s[28] = 1'b1;
    s[27] = m_busy;
    s[26] = 1'b1;
    s[23] = m_dis;
    s[22:17] = m_mode[5:0];
    s[16] = m_mode[6];
    return s;
  endfunction

  function automatic int exp_width();
    if (m_mode[1]) return m_mode[0] ? 640 : 512;
    if (m_mode[6]) return m_mode[0] ? 384 : 368;
    return m_mode[0] ? 320 : 256;
  endfunction

  function automatic int exp_height();
    if (m_mode[2]) return 480;
    return m_mode[3] ? 256 : 240;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    chk(req, "status", status, exp_status());
    chk(req, "width", width, exp_width());
    chk(req, "height", height, exp_height());
    chk(req, "pal", pal, m_mode[3]);
    chk(req, "depth24", depth24, m_mode[4]);
    chk(req, "disp_x", disp_x, m_x);
    chk(req, "disp_y", disp_y, m_y);
    chk(req, "vstart", vstart, m_vs);
    chk(req, "vend", vend, m_ve);
    chk(req, "readback", readback, m_rb);
    chk(req, "abort", abort_p, m_abort);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_field = 0; m_busy = 0; m_dis = 1; m_abort = 0; m_dma = 0; m_mode = 0;
      m_x = 0; m_y = 0; m_vs = 0; m_ve = 240; m_rb = 0;
    end else begin
      m_abort = 0;
      if (vblank) m_field = !m_field;
      if (xstart) m_busy = 1;
      if (valid) begin
        case (cmd[31:24])
          8'h00, 8'h01: begin m_busy = 0; m_abort = 1; end
          8'h03: m_dis = cmd[0];
          8'h04: m_dma = cmd[1:0];
          8'h05: begin m_x = cmd % 1024; m_y = (cmd / 1024) % 512; end
          8'h07: begin m_vs = cmd % 1024; m_ve = (cmd / 1024) % 1024; end
          8'h08: m_mode = cmd[6:0];
          8'h10: begin
            case (cmd[7:0])
              8'd2: m_rb = {12'd0, tex_win};
              8'd3: m_rb = ay0 * 1024 + ax0;
              8'd4: m_rb = ((ay1 + 1023) % 1024) * 1024 + (ax1 + 1023) % 1024;
              8'd5, 8'd6: m_rb = oy * 2048 + ox;
              8'd7: m_rb = 2;
              8'd8, 8'd15: m_rb = 32'hBFC0_3720;
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    #3;
    if (cmp_en) compare_all(cur_req);
  end

  function automatic string tag_of(logic [31:0] c);
    case (c[31:24])
      8'h00, 8'h01: return "R2";
      8'h03: return "R3";
      8'h04: return "R4";
      8'h05: return "R5";
      8'h07: return "R6";
      8'h08: return "R7/R8";
      8'h10: return (c[7:0] inside {2, 3, 4, 5, 6, 7, 8, 15}) ? "R9" : "R11";
      default: return "R11";
    endcase
  endfunction

  task automatic send(logic [31:0] c);
    @(negedge clk);
    cmd = c; valid = 1'b1; cur_req = tag_of(c);
    @(negedge clk);
    valid = 1'b0; cmd = $urandom;
  endtask

  task automatic pulse_vblank();
    @(negedge clk);
    vblank = 1'b1; cur_req = "R10";
    @(negedge clk);
    vblank = 1'b0;
  endtask

  task automatic shuffle_inputs();
    tex_win = 20'($urandom);
    ax0 = 10'($urandom); ay0 = 10'($urandom);
    ax1 = 11'($urandom); ay1 = 11'($urandom);
    ox = 11'($urandom); oy = 11'($urandom);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "status", status, 32'h1480_2000);
    chk("R1", "width", width, 256);
    chk("R1", "height", height, 240);
    chk("R1", "vend", vend, 240);
    chk("R1", "readback", readback, 0);
    chk("R1", "abort", abort_p, 0);
    rst_n = 1'b1;
    cmp_en = 1;
    repeat (2) @(negedge clk);

    // R2: transfer busy set / clear, clear wins on collision
    @(negedge clk); xstart = 1'b1; cur_req = "R2";
    @(negedge clk); xstart = 1'b0;
    send(32'h0100_0000);
    @(negedge clk); xstart = 1'b1;
    send(32'h0000_0000);
    xstart = 1'b0;
    @(negedge clk);
    chk("R2", "busy after collision", status[27], 0);

    // R3, R4
    send(32'h0300_0000);
    send(32'h0300_0001);
    for (int d = 0; d < 4; d++) send(32'h0400_0000 | d);

    // R5, R6 with boundary values
    send(32'h0500_0000 | (511 << 10) | 1023);
    chk("R5", "disp_x max", disp_x, 1023);
    chk("R5", "disp_y max", disp_y, 511);
    send(32'h0500_0000 | (7 << 10) | 300);
    send(32'h0700_0000 | (1023 << 10) | 1023);
    send(32'h0700_0000 | (264 << 10) | 16);
    chk("R6", "vend", vend, 264);

    // R7/R8: every mode value
    for (int m = 0; m < 128; m++) send(32'h0800_0000 | m);
    send(32'h0800_0040);
    chk("R8", "width idx1", width, 368);
    send(32'h0800_0041);
    chk("R8", "width idx3", width, 384);
    send(32'h0800_0008);
    chk("R8", "height idx2", height, 256);
    chk("R8", "pal", pal, 1);
    send(32'h0800_0014);
    chk("R8", "height idx1", height, 480);
    chk("R8", "depth24", depth24, 1);

    // R9, R11: all query indices 0..31 plus high-byte aliases
    for (int q = 0; q < 32; q++) begin
      shuffle_inputs();
      send(32'h1000_0000 | q);
    end
    ax1 = 11'd0; ay1 = 11'd0;
    send(32'h1000_0004);
    chk("R9", "corner wrap", readback, 32'h000F_FFFF);
    send(32'h1000_0102);
    send(32'h1000_0007);
    chk("R9", "version", readback, 2);

    // R11: unknown opcodes
    foreach (cmd[i]) if (i < 1) ;
    send(32'h0200_FFFF);
    send(32'h0600_1234);
    for (int o = 9; o < 16; o++) send((o << 24) | 32'h00FF_FFFF);
    send(32'h1100_0002);
    send(32'hFF00_0008);

    // R10
    pulse_vblank();
    pulse_vblank();
    @(negedge clk); vblank = 1'b1; cmd = 32'h0300_0000; valid = 1'b1; cur_req = "R10";
    @(negedge clk); vblank = 1'b0; valid = 1'b0;
    chk("R10", "field with cmd", status[23], 0);

    // R12: mixed random traffic
    for (int k = 0; k < 600; k++) begin
      logic [31:0] c;
      logic [7:0]  op_list [10];
      op_list = '{8'h00, 8'h01, 8'h03, 8'h04, 8'h05, 8'h07, 8'h08, 8'h10, 8'h06, 8'h22};
      c = $urandom;
      c[31:24] = op_list[$urandom % 10];
      if (c[31:24] == 8'h10) c[7:0] = 8'($urandom % 18);
      @(negedge clk);
      shuffle_inputs();
      valid = 1'($urandom % 2);
      cmd = c;
      vblank = 1'($urandom % 4 == 0);
      xstart = 1'($urandom % 5 == 0);
      cur_req = valid ? tag_of(c) : "R12";
    end
    @(negedge clk);
    valid = 1'b0; vblank = 1'b0; xstart = 1'b0;
    repeat (3) @(negedge clk);
    cmp_en = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule